// File: doc/BRIEF.md
# Long Immediate Assembly Unit

This block sits in the decode stage of a transport-triggered core whose instruction word holds three 16-bit move slots plus a small header. Each instruction selects one template through a 2-bit header field. The template decides which slots are ordinary data moves and which slots carry pieces of a wide constant. When a template claims slots, the unit joins their bits into one constant. At the clock edge that ends the decode cycle, it writes that constant into a small immediate register file. The datapath can only read that file. No transport bus can write it.

Each slot that stays a data move gets a registered move-enable flag. When a slot's source-type bit marks its source field as a short immediate, the unit also presents that 6-bit field sign-extended to 32 bits. The immediate file has two combinational read ports. Each port is addressed by its own index input.

The template field acts as the mode selector, and it has four named modes:
- **NONE** (code 0): no constant; all three slots move.
- **WIDE** (code 1): slots 1 and 2 form a 32-bit constant.
- **HALF** (code 2): slot 2 alone forms a zero-extended constant.
- **RSVD** (code 3): decoded exactly like NONE.

Each valid instruction makes one transition, from its decode cycle to the registered outputs and file contents of the following cycle. A cycle without a valid instruction transitions to idle outputs.

Top module: `lim_assembly_unit`

## Requirements
- R1: While rst_n is low, and after its release until the first valid instruction, both immediate registers read 0, move_en is 000 and every short-immediate output is 0.
- R2: Instruction bit layout: slot k occupies bits [16k+15:16k]; template code is bits [49:48]; destination index is bit 50. A valid instruction with template 0 sets move_en to 111 in the next cycle and writes no immediate register.
- R3: A valid instruction with template 1 sets move_en to 001 in the next cycle and writes {slot2, slot1} (slot 2 in the upper half) into the register chosen by bit 50.
- R4: A valid instruction with template 2 sets move_en to 011 in the next cycle and writes {16'h0000, slot2} into the register chosen by bit 50.
- R5: Template 3 behaves exactly like template 0: move_en 111, no register write.
- R6: Only the register chosen by the destination index changes; the other register keeps its value, and each read port returns the register named by its own index.
- R7: A read in the decode cycle returns the old register value; the new value is visible from the cycle after the write edge, including for back-to-back writes to the same register.
- R8: For a slot that moves, with slot bit 6 set, its short-immediate output in the next cycle is slot bits [5:0] sign-extended to 32 bits. It is 0 when bit 6 is clear or when the slot carries long-immediate bits.
- R9: In a cycle with instr_valid low, no register is written, and in the next cycle move_en is 000 and all short-immediate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 51 | Three slots, template code, destination index |
| rd_idx | input | 2 | Read index per port, port p at bit p |
| rd_data | output | 64 | Read data per port, port p at [32p+31:32p] |
| move_en | output | 3 | Registered per-slot data-move enable |
| simm | output | 96 | Registered per-slot short immediate, slot k at [32k+31:32k] |

## Verification
Two functions can fall in the same cycle.

The first collision is a decode that writes an immediate register while a read port is addressed to that same register. The bench always points port 0 at the destination while it issues. It expects the old value just after the drive and the new value after the edge. Back-to-back writes to one register check that each value becomes visible in turn.

The second collision is a slot with its short-immediate bit set that a template also claims for constant bits. That slot must drop both its move flag and its short value, while the other slots keep theirs.

// File: rtl/lim_pkg.sv
package lim_pkg;
    localparam int SLOT_W    = 16;
    localparam int NUM_SLOTS = 3;
    localparam int IMM_W     = 32;
    localparam int NUM_IREG  = 2;
    localparam int NUM_RD    = 2;
    localparam int SIMM_W    = 6;
    localparam int FLAG_BIT  = 6;
    localparam int TPL_W     = 2;

    typedef enum logic [TPL_W-1:0] {
        TPL_NONE = 2'd0,
        TPL_WIDE = 2'd1,
        TPL_HALF = 2'd2,
        TPL_RSVD = 2'd3
    } tpl_e;
endpackage

// File: rtl/lim_tpl_dec.sv
module lim_tpl_dec
    import lim_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int S_W    = SLOT_W,
    parameter int I_W    = IMM_W
) (
    input  tpl_e                  tpl,
    input  logic [N_SLOT*S_W-1:0] slots,
    output logic [N_SLOT-1:0]     lim_mask,
    output logic                  lim_wr,
    output logic [I_W-1:0]        lim_value
);
    localparam int HI = N_SLOT - 1;
    localparam int LO = N_SLOT - 2;

    logic [S_W-1:0] hi_slot, lo_slot;

    assign hi_slot = slots[HI*S_W +: S_W];
    assign lo_slot = slots[LO*S_W +: S_W];

    always_comb begin
        lim_mask  = '0;
        lim_wr    = 1'b0;
        lim_value = '0;
        unique case (tpl)
            TPL_WIDE: begin
                lim_mask[HI] = 1'b1;
                lim_mask[LO] = 1'b1;
                lim_wr       = 1'b1;
                lim_value    = I_W'({hi_slot, lo_slot});
            end
            TPL_HALF: begin
                lim_mask[HI] = 1'b1;
                lim_wr       = 1'b1;
                lim_value    = I_W'(hi_slot);
            end
            TPL_NONE, TPL_RSVD: begin
                lim_wr = 1'b0;
            end
            default: begin
                lim_wr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lim_slot_dec.sv
module lim_slot_dec
    import lim_pkg::*;
#(
    parameter int S_W  = SLOT_W,
    parameter int I_W  = IMM_W,
    parameter int SI_W = SIMM_W,
    parameter int FLAG = FLAG_BIT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue,
    input  logic           carries_lim,
    input  logic [S_W-1:0] slot,
    output logic           move_en,
    output logic [I_W-1:0] simm
);
    logic           is_move;
    logic [I_W-1:0] ext_value;

    assign is_move   = issue & ~carries_lim;
    assign ext_value = {{(I_W-SI_W){slot[SI_W-1]}}, slot[SI_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            move_en <= 1'b0;
            simm    <= '0;
        end else begin
            move_en <= is_move;
            simm    <= (is_move && slot[FLAG]) ? ext_value : '0;
        end
    end

    assert_claimed_slot_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && carries_lim) |=> (!move_en && simm == '0));

    assert_idle_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!move_en && simm == '0));
endmodule

// File: rtl/lim_imm_unit.sv
module lim_imm_unit
    import lim_pkg::*;
#(
    parameter int N_REG = NUM_IREG,
    parameter int I_W   = IMM_W,
    parameter int N_RD  = NUM_RD,
    parameter int IX_W  = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IX_W-1:0]    wr_idx,
    input  logic [I_W-1:0]     wr_data,
    input  logic [N_RD*IX_W-1:0] rd_idx,
    output logic [N_RD*I_W-1:0]  rd_data
);
    logic [N_REG-1:0][I_W-1:0] regs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        logic [IX_W-1:0] idx;
        assign idx = rd_idx[p*IX_W +: IX_W];
        assign rd_data[p*I_W +: I_W] = (int'(idx) < N_REG) ? regs[idx] : '0;
    end

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> regs == '0);
endmodule

// File: rtl/lim_assembly_unit.sv
module lim_assembly_unit
    import lim_pkg::*;
#(
    parameter int N_SLOT  = NUM_SLOTS,
    parameter int S_W     = SLOT_W,
    parameter int I_W     = IMM_W,
    parameter int N_REG   = NUM_IREG,
    parameter int N_RD    = NUM_RD,
    parameter int SI_W    = SIMM_W,
    parameter int FLAG    = FLAG_BIT,
    parameter int IX_W    = (N_REG > 1) ? $clog2(N_REG) : 1,
    parameter int INSTR_W = N_SLOT*S_W + TPL_W + IX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   instr_valid,
    input  logic [INSTR_W-1:0]     instr_word,
    input  logic [N_RD*IX_W-1:0]   rd_idx,
    output logic [N_RD*I_W-1:0]    rd_data,
    output logic [N_SLOT-1:0]      move_en,
    output logic [N_SLOT*I_W-1:0]  simm
);
    localparam int SLOTS_W = N_SLOT*S_W;
    localparam int TPL_LSB = SLOTS_W;
    localparam int DST_LSB = SLOTS_W + TPL_W;

    tpl_e                tpl;
    logic [IX_W-1:0]     dst_idx;
    logic [SLOTS_W-1:0]  slots;
    logic [N_SLOT-1:0]   lim_mask;
    logic                lim_wr;
    logic [I_W-1:0]      lim_value;
    logic                iu_wr;

    assign slots   = instr_word[SLOTS_W-1:0];
    assign tpl     = tpl_e'(instr_word[TPL_LSB +: TPL_W]);
    assign dst_idx = instr_word[DST_LSB +: IX_W];
    assign iu_wr   = instr_valid & lim_wr;

    lim_tpl_dec #(.N_SLOT(N_SLOT), .S_W(S_W), .I_W(I_W)) u_tpl (
        .tpl       (tpl),
        .slots     (slots),
        .lim_mask  (lim_mask),
        .lim_wr    (lim_wr),
        .lim_value (lim_value)
    );

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        lim_slot_dec #(.S_W(S_W), .I_W(I_W), .SI_W(SI_W), .FLAG(FLAG)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue       (instr_valid),
            .carries_lim (lim_mask[k]),
            .slot        (slots[k*S_W +: S_W]),
            .move_en     (move_en[k]),
            .simm        (simm[k*I_W +: I_W])
        );
    end

    lim_imm_unit #(.N_REG(N_REG), .I_W(I_W), .N_RD(N_RD), .IX_W(IX_W)) u_iu (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (iu_wr),
        .wr_idx  (dst_idx),
        .wr_data (lim_value),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // R3 / R4: a claimed slot never moves in the following cycle
    assert_claimed_lanes_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (move_en & $past(lim_mask)) == '0);

    assert_reserved_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && tpl == TPL_RSVD) |-> !iu_wr);

    assert_plain_all_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && tpl == TPL_NONE) |=> move_en == '1);
endmodule

// File: tb/test_lim_assembly_unit.sv
module test_lim_assembly_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [50:0] instr_word;
    logic [1:0]  rd_idx;
    logic [63:0] rd_data;
    logic [2:0]  move_en;
    logic [95:0] simm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] ref_iu [2];

    always #5 clk = ~clk;

    lim_assembly_unit i_lim_assembly_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .move_en     (move_en),
        .simm        (simm)
    );

    // {valid, dst, tpl, slot2, slot1, slot0, expected move_en}
    localparam logic [54:0] VEC [8] = '{
        {1'b1, 1'b0, 2'd0, 16'h1234, 16'h007F, 16'h0041, 3'b111},
        {1'b1, 1'b0, 2'd1, 16'hDEAD, 16'hBEEF, 16'h0060, 3'b001},
        {1'b1, 1'b1, 2'd2, 16'h8001, 16'h0045, 16'h0000, 3'b011},
        {1'b1, 1'b1, 2'd3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 3'b111},
        {1'b0, 1'b1, 2'd1, 16'h3333, 16'h2222, 16'h1111, 3'b000},
        {1'b1, 1'b1, 2'd1, 16'h1234, 16'h5678, 16'h0003, 3'b001},
        {1'b1, 1'b0, 2'd2, 16'hFFFF, 16'h00C1, 16'h0000, 3'b011},
        {1'b1, 1'b0, 2'd0, 16'h0040, 16'h007E, 16'h0020, 3'b111}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic claimed(input int k, input logic [1:0] tpl);
        return (tpl == 2'd1 && k >= 1) || (tpl == 2'd2 && k == 2);
    endfunction

    function automatic logic [31:0] simm_ref(input logic v, input logic [1:0] tpl,
                                             input int k, input logic [15:0] s);
        if (v && !claimed(k, tpl) && s[6]) return {{26{s[5]}}, s[5:0]};
        return 32'h0;
    endfunction

    function automatic string tag(input logic v, input logic [1:0] tpl);
        if (!v) return "R9";
        case (tpl)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // called at a falling edge; returns at the falling edge one cycle later
    task automatic issue(input logic v, input logic dst, input logic [1:0] tpl,
                         input logic [15:0] s2, input logic [15:0] s1, input logic [15:0] s0,
                         input logic [2:0] me_exp);
        logic [15:0] s [3];
        s[0] = s0; s[1] = s1; s[2] = s2;
        instr_valid = v;
        instr_word  = {dst, tpl, s2, s1, s0};
        rd_idx      = {~dst, dst};
        #1;
        chk("R7", "read during decode", rd_data[31:0], ref_iu[dst]);
        @(posedge clk);
        if (v && tpl == 2'd1) ref_iu[dst] = {s2, s1};
        if (v && tpl == 2'd2) ref_iu[dst] = {16'h0000, s2};
        @(negedge clk);
        chk(tag(v, tpl), "move_en", {29'b0, move_en}, {29'b0, me_exp});
        for (int k = 0; k < 3; k++)
            chk("R8", $sformatf("simm slot %0d", k), simm[k*32 +: 32], simm_ref(v, tpl, k, s[k]));
        chk("R6", "read port 0 after edge", rd_data[31:0],  ref_iu[dst]);
        chk("R6", "read port 1 other reg",  rd_data[63:32], ref_iu[~dst]);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        instr_valid = 1'b0;
        instr_word  = '0;
        rd_idx      = 2'b10;
        ref_iu[0]   = 32'h0;
        ref_iu[1]   = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "move_en after reset", {29'b0, move_en}, 32'h0);
        chk("R1", "simm after reset", simm[31:0] | simm[63:32] | simm[95:64], 32'h0);
        chk("R1", "reg0 after reset", rd_data[31:0], 32'h0);
        chk("R1", "reg1 after reset", rd_data[63:32], 32'h0);

        for (int i = 0; i < 8; i++)
            issue(VEC[i][54], VEC[i][53], VEC[i][52:51], VEC[i][50:35],
                  VEC[i][34:19], VEC[i][18:3], VEC[i][2:0]);

        // R7: back-to-back writes to the same register
        issue(1'b1, 1'b1, 2'd1, 16'hAAAA, 16'h5555, 16'h0000, 3'b001);
        issue(1'b1, 1'b1, 2'd2, 16'h00FF, 16'h0000, 16'h0000, 3'b011);
        // R8: flagged short immediate in a claimed slot, neighbour still moves
        issue(1'b1, 1'b0, 2'd2, 16'h007F, 16'h0050, 16'h0000, 3'b011);
        // R9: idle cycle after activity
        issue(1'b0, 1'b0, 2'd0, 16'h0041, 16'h0041, 16'h0041, 3'b000);

        // R1: reset in mid-run clears everything at once
        instr_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        ref_iu[0] = 32'h0;
        ref_iu[1] = 32'h0;
        chk("R1", "move_en in reset", {29'b0, move_en}, 32'h0);
        chk("R1", "reg0 in reset", rd_data[31:0] | rd_data[63:32], 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 1'b0, 2'd1, 16'h0BAD, 16'hF00D, 16'h0000, 3'b001);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule